// File: doc/BRIEF.md
# Configurable Synchronous/Asynchronous Serial Transmitter

This block is the transmit half of a serial port. Software programs one 8-bit control/status register to pick the framing and clocking, then writes data bytes into a holding register. The engine moves each byte into its shift register and sends it out on a single data line. In asynchronous mode it frames the byte with a start bit and a stop bit and times every bit from an external baud tick. In synchronous mode it sends bare data bits, LSB first. As clock master it drives the shift clock from the same tick. As clock slave it follows an externally supplied clock. A ninth data bit can be appended from a register field. A read-only status bit shows whether the shift register is empty.

The baud tick comes from a divider outside the block. In asynchronous mode the high-speed select stretches each bit to 16 ticks or 64 ticks. In synchronous master mode every tick toggles the shift clock. In synchronous mode, an active receive enable (single or continuous) takes the line for reception and so suppresses transmission.

Top module: `ser_tx_engine`

## Requirements
- R1: After reset the control register reads 0x02: every writable field is 0 and the empty status (bit 1) is 1. The data line is high and the shift clock output is low.
- R2: Bits 7 (clock master), 6 (nine-bit), 5 (transmit enable), 4 (synchronous), 2 (high speed) and 0 (ninth data bit) are written by a register write and read back unchanged. Bit 3 always reads 0. Bit 1 is status only, so a write to it has no effect.
- R3: If the shift register is empty and transmit is enabled, writing the holding register loads the shift register on the next clock edge. The empty status then reads 0. It reads 1 again once the last bit of the frame has been shifted out.
- R4: An asynchronous frame is a 0 start bit, then the data LSB first, then a 1 stop bit, and the line idles high. Each bit lasts 16 baud ticks when bit 2 is 1 and 64 baud ticks when bit 2 is 0.
- R5: When bit 6 is 1 a ninth data bit, taken from bit 0, follows the eight data bits in both modes. When bit 6 is 0 only eight data bits are sent.
- R6: In synchronous master mode (bits 7 and 4 both 1), the clock output enable is 1 and the clock idles low. Each baud tick toggles the clock. Data changes on the falling clock edge, one bit per clock period, LSB first. Bit 2 has no effect on the timing.
- R7: In synchronous slave mode (bit 4 is 1, bit 7 is 0), the clock output enable is 0. The engine synchronises the external clock and moves to the next bit after each falling edge of it.
- R8: In synchronous mode, an asserted single-receive or continuous-receive enable stops any frame within one cycle and prevents loading. A held byte is sent once both enables are released.
- R9: When transmit enable is 0, the engine is idle in the following cycle: the empty status reads 1 and the line is high. A frame that was in progress is abandoned.
- R10: In asynchronous mode bit 7 has no effect: the frame is unchanged and the shift clock output stays low with its enable at 0.
- R11: A byte written while a frame is in progress is held. It loads one cycle after that frame ends, so the empty status reads 1 for exactly one cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value including status |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Data byte to send |
| baud_tick | input | 1 | One-cycle rate tick from the external divider |
| rx_single_en | input | 1 | Single-receive enable from the receiver |
| rx_cont_en | input | 1 | Continuous-receive enable from the receiver |
| ser_clk_in | input | 1 | External shift clock for slave mode |
| ser_clk_out | output | 1 | Generated shift clock in master mode |
| ser_clk_oe | output | 1 | Drive enable for the shift clock pin |
| txd_out | output | 1 | Serial data line |

## Verification
Most internal state errors appear on the data line within one frame. A bad bit counter gives a frame that is too short or too long. A stuck or misaligned clock phase shifts every later bit. A wrong frame image corrupts the start, ninth or stop bit at its first mid-bit sample. A busy flag that does not clear, or that clears early, shows in the empty status. When frames are sent back to back, it also shows as a missing or extra idle cycle between them. Errors in the override and abort paths show in the empty status one cycle after the enable changes.

// File: rtl/ser_tx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial transmit engine.
// Field positions are part of the software-visible register layout.
package ser_tx_pkg;
    localparam int FLD_MASTER = 7;
    localparam int FLD_NINE   = 6;
    localparam int FLD_TXEN   = 5;
    localparam int FLD_SYNC   = 4;
    localparam int FLD_RSVD   = 3;
    localparam int FLD_HISPD  = 2;
    localparam int FLD_EMPTY  = 1;
    localparam int FLD_D9     = 0;

    // Writable configuration fields held by the control register.
    typedef struct packed {
        logic master;
        logic nine;
        logic tx_en;
        logic sync_mode;
        logic hi_speed;
        logic d9;
    } tx_cfg_t;
endpackage

// File: rtl/ser_tx_ctl_reg.sv
`timescale 1ns/1ps
// Control/status register.
// Holds the writable configuration fields and builds the read value.
// The reserved bit reads 0. The empty bit is driven by the shifter.
// Assumes single-cycle write strobes.
module ser_tx_ctl_reg
    import ser_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       shift_empty,
    output tx_cfg_t    cfg,
    output logic [7:0] rdata
);
    // Capture the writable fields; reserved and status bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.master    <= wdata[FLD_MASTER];
            cfg.nine      <= wdata[FLD_NINE];
            cfg.tx_en     <= wdata[FLD_TXEN];
            cfg.sync_mode <= wdata[FLD_SYNC];
            cfg.hi_speed  <= wdata[FLD_HISPD];
            cfg.d9        <= wdata[FLD_D9];
        end
    end

    // Assemble the read value in register layout.
    always_comb begin
        rdata             = '0;
        rdata[FLD_MASTER] = cfg.master;
        rdata[FLD_NINE]   = cfg.nine;
        rdata[FLD_TXEN]   = cfg.tx_en;
        rdata[FLD_SYNC]   = cfg.sync_mode;
        rdata[FLD_RSVD]   = 1'b0;
        rdata[FLD_HISPD]  = cfg.hi_speed;
        rdata[FLD_EMPTY]  = shift_empty;
        rdata[FLD_D9]     = cfg.d9;
    end
endmodule

// File: rtl/ser_tx_timing.sv
`timescale 1ns/1ps
// Bit timing for the serial transmit engine.
// Produces a one-cycle bit strobe for the shifter. In async mode it divides
// the baud tick. In sync master mode it generates the shift clock from the
// tick. In sync slave mode it synchronises the external clock and detects
// its falling edge.
// Assumes baud_tick pulses last one cycle and that the external clock is much
// slower than clk.
module ser_tx_timing #(
    parameter int LO_DIV      = 64,
    parameter int HI_DIV      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic master,
    input  logic hi_speed,
    input  logic busy,
    input  logic load,
    input  logic abort,
    input  logic baud_tick,
    input  logic ser_clk_in,
    output logic bit_strobe,
    output logic ser_clk_out
);
    localparam int MAX_DIV = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV;
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_DIV - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_DIV - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] div_last;
    logic             mclk;
    logic             sck_now;
    logic             sck_prev;
    logic             sck_fall;
    logic             restart;

    assign div_last = hi_speed ? HI_LAST : LO_LAST;
    assign restart  = load | abort | ~busy;

    // Count baud ticks inside the current async bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_cnt <= '0;
        end else if (baud_tick && !sync_mode) begin
            tick_cnt <= (tick_cnt == div_last) ? '0 : tick_cnt + 1'b1;
        end
    end

    // Generate the master shift clock; it idles low and toggles per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            mclk <= 1'b0;
        end else if (baud_tick && sync_mode && master) begin
            mclk <= ~mclk;
        end
    end

    // Synchroniser depth is picked by a parameter.
    generate
        if (SYNC_STAGES < 2) begin : g_sync_one
            logic s1;
            // Single-flop capture of the external clock.
            always_ff @(posedge clk) begin
                if (!rst_n) s1 <= 1'b0;
                else        s1 <= ser_clk_in;
            end
            assign sck_now = s1;
        end else begin : g_sync_chain
            logic [SYNC_STAGES-1:0] chain;
            // Multi-flop capture of the external clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], ser_clk_in};
            end
            assign sck_now = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_now;
    end

    assign sck_fall = sck_prev & ~sck_now;

    // Choose the bit strobe source for the active mode.
    always_comb begin
        if (!busy) begin
            bit_strobe = 1'b0;
        end else if (!sync_mode) begin
            bit_strobe = baud_tick & (tick_cnt == div_last);
        end else if (master) begin
            bit_strobe = baud_tick & mclk;
        end else begin
            bit_strobe = sck_fall;
        end
    end

    assign ser_clk_out = mclk & sync_mode & master;
endmodule

// File: rtl/ser_tx_shifter.sv
`timescale 1ns/1ps
// Transmit shift register and bit counter.
// On load it builds the frame image for the mode: async adds start and stop
// bits, sync sends data only. The optional ninth bit follows the data.
// Shifts LSB first on each strobe and clears busy after the last bit.
// Assumes the frame length fits in the counter derived from DATA_W.
module ser_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              abort,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data,
    input  logic              nine,
    input  logic              d9,
    input  logic              sync_mode,
    output logic              busy,
    output logic              line
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int BCNT_W  = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sreg;
    logic [FRAME_W-1:0] frame;
    logic [BCNT_W-1:0]  bits_left;
    logic [BCNT_W-1:0]  frame_len;

    // Build the frame image and its length for the current settings.
    always_comb begin
        if (sync_mode) begin
            frame     = {2'b11, d9, data};
            frame_len = nine ? BCNT_W'(DATA_W + 1) : BCNT_W'(DATA_W);
        end else begin
            frame     = {1'b1, (nine ? d9 : 1'b1), data, 1'b0};
            frame_len = nine ? BCNT_W'(FRAME_W) : BCNT_W'(FRAME_W - 1);
        end
    end

    // Load, shift and retire the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            sreg      <= '1;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            sreg      <= frame;
            bits_left <= frame_len;
            busy      <= 1'b1;
        end else if (strobe) begin
            sreg      <= {1'b1, sreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BCNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign line = busy ? sreg[0] : 1'b1;
endmodule

// File: rtl/ser_tx_engine.sv
`timescale 1ns/1ps
// Configurable serial transmit engine: async framing or sync master/slave.
// Ties together the control register, holding register, timing and shifter.
// In sync mode an active receive enable overrides the transmit enable.
// Assumes the baud divider, receiver and pin multiplexing are outside.
module ser_tx_engine
    import ser_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LO_DIV      = 64,
    parameter int HI_DIV      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              baud_tick,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              ser_clk_in,
    output logic              ser_clk_out,
    output logic              ser_clk_oe,
    output logic              txd_out
);
    tx_cfg_t           cfg;
    logic              busy;
    logic              run_en;
    logic              load;
    logic              strobe;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    assign run_en = cfg.tx_en & ~(cfg.sync_mode & (rx_single_en | rx_cont_en));
    assign load   = hold_full & ~busy & run_en;

    ser_tx_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctl_wr),
        .wdata       (ctl_wdata),
        .shift_empty (~busy),
        .cfg         (cfg),
        .rdata       (ctl_rdata)
    );

    // Holding register; a new write wins over a same-cycle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (hold_wr) begin
            hold_full <= 1'b1;
            hold_data <= hold_wdata;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    ser_tx_timing #(
        .LO_DIV      (LO_DIV),
        .HI_DIV      (HI_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode   (cfg.sync_mode),
        .master      (cfg.master),
        .hi_speed    (cfg.hi_speed),
        .busy        (busy),
        .load        (load),
        .abort       (~run_en),
        .baud_tick   (baud_tick),
        .ser_clk_in  (ser_clk_in),
        .bit_strobe  (strobe),
        .ser_clk_out (ser_clk_out)
    );

    ser_tx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .abort     (~run_en),
        .strobe    (strobe),
        .data      (hold_data),
        .nine      (cfg.nine),
        .d9        (cfg.d9),
        .sync_mode (cfg.sync_mode),
        .busy      (busy),
        .line      (txd_out)
    );

    assign ser_clk_oe = cfg.sync_mode & cfg.master;
endmodule

// File: rtl/ser_tx_engine_chk.sv
`timescale 1ns/1ps
// Assertion checker bound to the transmit engine top.
module ser_tx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_wr,
    input logic baud_tick,
    input logic rx_single_en,
    input logic rx_cont_en,
    input logic ser_clk_out,
    input logic txd_out,
    input logic rsvd_bit,
    input logic empty_bit,
    input logic sync_bit,
    input logic txen_bit
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_bit == 1'b0);

    assert_idle_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty_bit |-> !ser_clk_out);

    assert_rx_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_bit && (rx_single_en || rx_cont_en)) |=> empty_bit);

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !txen_bit |=> empty_bit);

    assert_async_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_bit && !empty_bit && $past(!empty_bit) && !$past(baud_tick) && !$past(ctl_wr))
        |-> $stable(txd_out));
endmodule

bind ser_tx_engine ser_tx_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .baud_tick    (baud_tick),
    .rx_single_en (rx_single_en),
    .rx_cont_en   (rx_cont_en),
    .ser_clk_out  (ser_clk_out),
    .txd_out      (txd_out),
    .rsvd_bit     (ctl_rdata[3]),
    .empty_bit    (ctl_rdata[1]),
    .sync_bit     (ctl_rdata[4]),
    .txen_bit     (ctl_rdata[5])
);

// File: tb/ser_tx_engine_test.sv
`timescale 1ns/1ps
module ser_tx_engine_test;
    localparam int TICK_P = 2;

    typedef struct {
        logic  b;
        string req;
    } exp_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       ctl_wr = 0;
    logic [7:0] ctl_wdata = 0;
    logic [7:0] ctl_rdata;
    logic       hold_wr = 0;
    logic [7:0] hold_wdata = 0;
    logic       baud_tick = 0;
    logic       rx_single_en = 0;
    logic       rx_cont_en = 0;
    logic       ser_clk_in = 0;
    logic       ser_clk_out;
    logic       ser_clk_oe;
    logic       txd_out;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t exp_q[$];
    int   len_q[$];
    bit   cfg_sync = 0, cfg_master = 0, cfg_hi = 0, cfg_nine = 0, cfg_d9 = 0;
    bit   mon_off = 0;

    ser_tx_engine uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .hold_wr(hold_wr), .hold_wdata(hold_wdata),
        .baud_tick(baud_tick), .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
        .ser_clk_in(ser_clk_in), .ser_clk_out(ser_clk_out), .ser_clk_oe(ser_clk_oe),
        .txd_out(txd_out)
    );

    initial forever #5 clk = ~clk;

    // Baud tick every TICK_P cycles, driven just after the edge.
    initial forever begin
        @(posedge clk); #1 baud_tick = 1;
        @(posedge clk); #1 baud_tick = 0;
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pop_cmp(logic act);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(0, "R4 unexpected bit", act, 0);
        end else begin
            e = exp_q.pop_front();
            check(act === e.b, e.req, act, e.b);
        end
    endtask

    // Monitor: samples the line at the points the requirements define.
    logic prev_line = 1, prev_sck = 0, sck;
    int   m_cnt = 0, m_idx = 0, m_len = 0, bitc;
    bit   m_act = 0;
    initial forever begin
        @(negedge clk);
        sck  = cfg_master ? ser_clk_out : ser_clk_in;
        bitc = (cfg_hi ? 16 : 64) * TICK_P;
        if (!rst_n || mon_off) begin
            m_act = 0;
        end else if (!cfg_sync) begin
            if (m_act) begin
                m_cnt++;
                if (m_cnt == bitc / 2 + m_idx * bitc) begin
                    pop_cmp(txd_out);
                    m_idx++;
                    if (m_idx >= m_len) m_act = 0;
                end
            end else if (prev_line && !txd_out) begin
                m_act = 1; m_cnt = 0; m_idx = 0;
                if (len_q.size() == 0) begin
                    check(0, "R4 unexpected frame", 0, 1);
                    m_len = 0; m_act = 0;
                end else begin
                    m_len = len_q.pop_front();
                end
            end
        end else if (sck && !prev_sck) begin
            pop_cmp(txd_out);
        end
        prev_line = txd_out;
        prev_sck  = sck;
    end

    task automatic wr_ctl(logic [7:0] v);
        @(posedge clk); #1;
        ctl_wr = 1; ctl_wdata = v;
        cfg_master = v[7]; cfg_nine = v[6]; cfg_sync = v[4]; cfg_hi = v[2]; cfg_d9 = v[0];
        @(posedge clk); #1;
        ctl_wr = 0;
    endtask

    // Driver: pushes the expected bits, then writes the holding register.
    task automatic send(logic [7:0] d, bit push);
        string dreq = cfg_sync ? (cfg_master ? "R6" : "R7") : "R4";
        if (push) begin
            if (!cfg_sync) exp_q.push_back('{1'b0, "R4 start"});
            for (int i = 0; i < 8; i++) exp_q.push_back('{d[i], dreq});
            if (cfg_nine) exp_q.push_back('{cfg_d9, "R5 ninth"});
            if (!cfg_sync) begin
                exp_q.push_back('{1'b1, "R4 stop"});
                len_q.push_back(cfg_nine ? 11 : 10);
            end
        end
        @(posedge clk); #1;
        hold_wr = 1; hold_wdata = d;
        @(posedge clk); #1;
        hold_wr = 0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!ctl_rdata[1]) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_clocks(int n);
        for (int i = 0; i < n; i++) begin
            ser_clk_in = 1; repeat (5) @(posedge clk); #1;
            ser_clk_in = 0; repeat (5) @(posedge clk); #1;
        end
    endtask

    task automatic busy_len(output int n);
        n = 0;
        @(negedge clk);
        @(negedge clk);
        while (!ctl_rdata[1]) begin n++; @(negedge clk); end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int d0, d1, gap;
        repeat (3) @(posedge clk); #1;
        @(negedge clk);
        check(ctl_rdata == 8'h02, "R1 reg", ctl_rdata, 8'h02);
        check(txd_out == 1, "R1 line", txd_out, 1);
        check(ser_clk_out == 0, "R1 clk", ser_clk_out, 0);
        @(posedge clk); #1 rst_n = 1;

        // R2: register read/write
        wr_ctl(8'hFF); @(negedge clk);
        check(ctl_rdata == 8'hF7, "R2 all ones", ctl_rdata, 8'hF7);
        wr_ctl(8'h0A); @(negedge clk);
        check(ctl_rdata == 8'h02, "R2 reserved/status", ctl_rdata, 8'h02);

        // R3, R4: async high speed, 8 bits
        wr_ctl(8'h24);
        send(8'hA5, 1);
        @(negedge clk);
        check(ctl_rdata[1] == 1, "R3 empty before load", ctl_rdata[1], 1);
        @(negedge clk);
        check(ctl_rdata[1] == 0, "R3 full after load", ctl_rdata[1], 0);
        wait_idle();
        check(ctl_rdata[1] == 1, "R3 empty after frame", ctl_rdata[1], 1);

        // R5: async low speed, nine bits, ninth = 1; R2 status write ignored
        wr_ctl(8'h61);
        send(8'h3C, 1);
        repeat (50) @(negedge clk);
        wr_ctl(8'h63); @(negedge clk);
        check(ctl_rdata == 8'h61, "R2 status not writable", ctl_rdata, 8'h61);
        wait_idle();

        // R11: back to back, nine bits with ninth = 0
        wr_ctl(8'h64);
        send(8'h81, 1);
        send(8'h7E, 1);
        while (ctl_rdata[1]) @(negedge clk);
        while (!ctl_rdata[1]) @(negedge clk);
        gap = 0;
        while (ctl_rdata[1] && gap < 10) begin gap++; @(negedge clk); end
        check(gap == 1, "R11 gap", gap, 1);
        wait_idle();

        // R10: clock master bit ignored in async
        wr_ctl(8'hA4);
        send(8'h5A, 1);
        repeat (100) @(negedge clk);
        check(ser_clk_out == 0 && ser_clk_oe == 0, "R10 no clock", {ser_clk_oe, ser_clk_out}, 0);
        wait_idle();

        // R6: sync master, high speed select has no effect
        wr_ctl(8'hB0);
        check(ser_clk_oe == 1, "R6 oe", ser_clk_oe, 1);
        send(8'hC3, 1);
        busy_len(d0);
        check(d0 >= 31 && d0 <= 32, "R6 length lo", d0, 32);
        check(ser_clk_out == 0, "R6 idle low", ser_clk_out, 0);
        wr_ctl(8'hB4);
        send(8'h96, 1);
        busy_len(d1);
        check(d1 >= 31 && d1 <= 32, "R6 length hi", d1, 32);
        repeat (4) @(negedge clk);

        // R5: sync master, nine bits with ninth = 1
        wr_ctl(8'hF1);
        send(8'h0F, 1);
        wait_idle();

        // R7: sync slave
        wr_ctl(8'h30); @(negedge clk);
        check(ser_clk_oe == 0, "R7 oe", ser_clk_oe, 0);
        send(8'h6B, 1);
        repeat (3) @(posedge clk); #1;
        slave_clocks(8);
        wait_idle();
        check(ctl_rdata[1] == 1, "R7 done", ctl_rdata[1], 1);

        // R8: receive enable overrides transmit in sync mode
        wr_ctl(8'hB0);
        rx_single_en = 1;
        send(8'h55, 1);
        repeat (20) @(negedge clk);
        check(ctl_rdata[1] == 1, "R8 held off", ctl_rdata[1], 1);
        check(ser_clk_out == 0, "R8 no clock", ser_clk_out, 0);
        @(posedge clk); #1 rx_single_en = 0;
        wait_idle();

        // R9: clearing transmit enable abandons the frame
        wr_ctl(8'h24);
        mon_off = 1;
        send(8'h00, 0);
        repeat (40) @(negedge clk);
        check(txd_out == 0, "R9 frame running", txd_out, 0);
        wr_ctl(8'h04);
        @(posedge clk); @(negedge clk);
        check(ctl_rdata[1] == 1, "R9 empty", ctl_rdata[1], 1);
        check(txd_out == 1, "R9 line idle", txd_out, 1);
        repeat (4) @(negedge clk);
        mon_off = 0;

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 all bits seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule